// File: doc/BRIEF.md
# Exception Vector Priority Resolver

This block sits beside a CPU core and turns a set of pending exception sources into a single vector address. The sources are reset causes, an unimplemented-opcode trap, a software-interrupt request, one request maskable by the CPU's X bit, and a parameterized bank of peripheral requests maskable by the CPU's I bit, each with its own local enable.

The CPU raises a one-cycle request strobe when it wants a vector. Arbitration happens only then, on the inputs present in that cycle. A request that appeared after the interrupt was first recognised can therefore take over. If nothing qualifies any more, the block returns a spurious-interrupt vector. The answer is registered: it appears one clock after the strobe, together with a one-cycle valid pulse, and it stays put until the next strobe.

Reset vectors are absolute addresses. Every other vector is a fixed offset from a programmable vector base, added modulo 2^ADDR_W.

Top module: `exc_vec_resolver`

## Requirements
- R1: `vec_valid` is high in exactly the cycles that follow a cycle in which `vec_req` was sampled high, and `vec_addr` takes its new value at that same edge.
- R2: After the synchronous reset `rst`, `vec_addr` is 0 and `vec_valid` is 0. Between strobes, `vec_addr` keeps its last value whatever the inputs do.
- R3: Reset causes win over everything, including all other requests sampled in the same cycle. Their order, highest first, is `rst_ext` (0xFFFE), then `rst_clkmon` (0xFFFC), then `rst_wdog` (0xFFFA). These addresses ignore `vec_base`.
- R4: With no reset cause, `trap_req` gives `vec_base`+0x00F8. Otherwise `swi_req` gives `vec_base`+0x00F6.
- R5: When neither a reset, a trap nor a software interrupt is pending, `xirq_req` gives `vec_base`+0x00F4 if `x_mask` is 0. It is ignored when `x_mask` is 1.
- R6: Peripheral line i qualifies only when all of these hold: `irq_req[i]` is 1, `irq_en[i]` is 1, `i_mask` is 0, and no trap, software interrupt or unmasked X request is pending. Its vector is `vec_base`+0x00F2−2·i.
- R7: When several peripheral lines qualify, the lowest index wins. That is the line with the highest vector address.
- R8: Arbitration uses only the inputs sampled in the strobe cycle. A request raised or dropped after earlier cycles changes the answer.
- R9: When no source qualifies at the strobe, the output is the spurious vector `vec_base`+0x0080.
- R10: Base-relative sums wrap modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_ext | input | 1 | External, power-on, illegal-address or low-voltage reset cause |
| rst_clkmon | input | 1 | Clock-monitor reset cause |
| rst_wdog | input | 1 | Watchdog reset cause |
| trap_req | input | 1 | Unimplemented-opcode trap request |
| swi_req | input | 1 | Software interrupt or debug vector request |
| xirq_req | input | 1 | X-maskable interrupt request |
| irq_req | input | NUM_IRQ | I-maskable peripheral request lines |
| irq_en | input | NUM_IRQ | Local enables, one per peripheral line |
| i_mask | input | 1 | CPU I mask bit (1 = masked) |
| x_mask | input | 1 | CPU X mask bit (1 = masked) |
| vec_base | input | ADDR_W | Vector base address |
| vec_req | input | 1 | CPU vector request strobe |
| vec_addr | output | ADDR_W | Resolved vector address, registered |
| vec_valid | output | 1 | One-cycle pulse marking a new `vec_addr` |

## Verification
The properties assume that all inputs are settled before the clock edge at which `vec_req` is sampled. They compare each result with `vec_base` as it was in the strobe cycle. They also assume the bank stays within 56 lines, so that peripheral vectors never reach down to the spurious offset. The stimulus drives every input on the falling edge only and keeps the default eight lines. Both directed and random phases may change `vec_base` and every request between strobes, so the hold and late-arbitration rules are exercised under changing inputs.

// File: rtl/exc_vec_pkg.sv
package exc_vec_pkg;

  typedef enum logic [2:0] {
    SRC_RST_EXT  = 3'd0,
    SRC_RST_CLK  = 3'd1,
    SRC_RST_WDOG = 3'd2,
    SRC_TRAP     = 3'd3,
    SRC_SWI      = 3'd4,
    SRC_XIRQ     = 3'd5,
    SRC_IRQ      = 3'd6,
    SRC_SPUR     = 3'd7
  } src_kind_e;

  localparam int unsigned VEC_RST_EXT  = 32'h0000_FFFE;
  localparam int unsigned VEC_RST_CLK  = 32'h0000_FFFC;
  localparam int unsigned VEC_RST_WDOG = 32'h0000_FFFA;

  localparam int unsigned OFS_TRAP = 32'h0000_00F8;
  localparam int unsigned OFS_SWI  = 32'h0000_00F6;
  localparam int unsigned OFS_XIRQ = 32'h0000_00F4;
  localparam int unsigned OFS_IRQ0 = 32'h0000_00F2;
  localparam int unsigned OFS_SPUR = 32'h0000_0080;

  localparam int unsigned MAX_IRQ = (OFS_IRQ0 - OFS_SPUR) / 2;

endpackage

// File: rtl/irq_qualify.sv
module irq_qualify #(
  parameter int NUM_IRQ = 8
) (
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic [NUM_IRQ-1:0] irq_en,
  input  logic               i_mask,
  input  logic               block_maskable,
  output logic [NUM_IRQ-1:0] irq_qual
);

  logic gate_open;
  assign gate_open = !i_mask && !block_maskable;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
    assign irq_qual[g] = irq_req[g] && irq_en[g] && gate_open;
  end

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int NUM_IRQ = 8,
  parameter int IDX_W   = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic [NUM_IRQ-1:0] irq_qual,
  output logic               irq_any,
  output logic [IDX_W-1:0]   irq_idx
);

  // Lowest index has the highest vector address, hence the highest rank.
  always_comb begin
    irq_any = 1'b0;
    irq_idx = '0;
    for (int k = NUM_IRQ - 1; k >= 0; k--) begin
      if (irq_qual[k]) begin
        irq_any = 1'b1;
        irq_idx = IDX_W'(k);
      end
    end
  end

endmodule

// File: rtl/exc_src_arbiter.sv
module exc_src_arbiter
  import exc_vec_pkg::*;
(
  input  logic      rst_ext,
  input  logic      rst_clkmon,
  input  logic      rst_wdog,
  input  logic      trap_req,
  input  logic      swi_req,
  input  logic      xirq_req,
  input  logic      x_mask,
  input  logic      irq_any,
  output logic      block_maskable,
  output src_kind_e kind
);

  logic xirq_live;
  assign xirq_live      = xirq_req && !x_mask;
  assign block_maskable = trap_req || swi_req || xirq_live;

  always_comb begin
    if (rst_ext)         kind = SRC_RST_EXT;
    else if (rst_clkmon) kind = SRC_RST_CLK;
    else if (rst_wdog)   kind = SRC_RST_WDOG;
    else if (trap_req)   kind = SRC_TRAP;
    else if (swi_req)    kind = SRC_SWI;
    else if (xirq_live)  kind = SRC_XIRQ;
    else if (irq_any)    kind = SRC_IRQ;
    else                 kind = SRC_SPUR;
  end

endmodule

// File: rtl/exc_vec_addr.sv
module exc_vec_addr
  import exc_vec_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 3
) (
  input  src_kind_e         kind,
  input  logic [IDX_W-1:0]  irq_idx,
  input  logic [ADDR_W-1:0] vec_base,
  output logic [ADDR_W-1:0] addr
);

  localparam logic [ADDR_W-1:0] A_RST_EXT  = ADDR_W'(VEC_RST_EXT);
  localparam logic [ADDR_W-1:0] A_RST_CLK  = ADDR_W'(VEC_RST_CLK);
  localparam logic [ADDR_W-1:0] A_RST_WDOG = ADDR_W'(VEC_RST_WDOG);
  localparam logic [ADDR_W-1:0] O_TRAP     = ADDR_W'(OFS_TRAP);
  localparam logic [ADDR_W-1:0] O_SWI      = ADDR_W'(OFS_SWI);
  localparam logic [ADDR_W-1:0] O_XIRQ     = ADDR_W'(OFS_XIRQ);
  localparam logic [ADDR_W-1:0] O_IRQ0     = ADDR_W'(OFS_IRQ0);
  localparam logic [ADDR_W-1:0] O_SPUR     = ADDR_W'(OFS_SPUR);

  logic [ADDR_W-1:0] irq_ofs;
  logic [ADDR_W-1:0] sel_ofs;
  logic              is_abs;
  logic [ADDR_W-1:0] abs_addr;

  assign irq_ofs = O_IRQ0 - (ADDR_W'(irq_idx) << 1);

  always_comb begin
    is_abs   = 1'b0;
    abs_addr = '0;
    sel_ofs  = O_SPUR;
    unique case (kind)
      SRC_RST_EXT:  begin is_abs = 1'b1; abs_addr = A_RST_EXT;  end
      SRC_RST_CLK:  begin is_abs = 1'b1; abs_addr = A_RST_CLK;  end
      SRC_RST_WDOG: begin is_abs = 1'b1; abs_addr = A_RST_WDOG; end
      SRC_TRAP:     sel_ofs = O_TRAP;
      SRC_SWI:      sel_ofs = O_SWI;
      SRC_XIRQ:     sel_ofs = O_XIRQ;
      SRC_IRQ:      sel_ofs = irq_ofs;
      default:      sel_ofs = O_SPUR;
    endcase
  end

  assign addr = is_abs ? abs_addr : (vec_base + sel_ofs);

endmodule

// File: rtl/exc_vec_resolver.sv
module exc_vec_resolver
  import exc_vec_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rst_ext,
  input  logic               rst_clkmon,
  input  logic               rst_wdog,
  input  logic               trap_req,
  input  logic               swi_req,
  input  logic               xirq_req,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic [NUM_IRQ-1:0] irq_en,
  input  logic               i_mask,
  input  logic               x_mask,
  input  logic [ADDR_W-1:0]  vec_base,
  input  logic               vec_req,
  output logic [ADDR_W-1:0]  vec_addr,
  output logic               vec_valid
);

  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  logic [NUM_IRQ-1:0] irq_qual;
  logic               irq_any;
  logic [IDX_W-1:0]   irq_idx;
  logic               block_maskable;
  src_kind_e          kind;
  logic [ADDR_W-1:0]  next_addr;

  irq_qualify #(.NUM_IRQ(NUM_IRQ)) u_qual (
    .irq_req        (irq_req),
    .irq_en         (irq_en),
    .i_mask         (i_mask),
    .block_maskable (block_maskable),
    .irq_qual       (irq_qual)
  );

  irq_prio_enc #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) u_enc (
    .irq_qual (irq_qual),
    .irq_any  (irq_any),
    .irq_idx  (irq_idx)
  );

  exc_src_arbiter u_arb (
    .rst_ext        (rst_ext),
    .rst_clkmon     (rst_clkmon),
    .rst_wdog       (rst_wdog),
    .trap_req       (trap_req),
    .swi_req        (swi_req),
    .xirq_req       (xirq_req),
    .x_mask         (x_mask),
    .irq_any        (irq_any),
    .block_maskable (block_maskable),
    .kind           (kind)
  );

  exc_vec_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_addr (
    .kind     (kind),
    .irq_idx  (irq_idx),
    .vec_base (vec_base),
    .addr     (next_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_addr  <= '0;
      vec_valid <= 1'b0;
    end else begin
      vec_valid <= vec_req;
      if (vec_req) vec_addr <= next_addr;
    end
  end

endmodule

// File: rtl/exc_vec_resolver_chk.sv
module exc_vec_resolver_chk #(
  parameter int ADDR_W  = 16,
  parameter int NUM_IRQ = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               rst_ext,
  input logic               rst_clkmon,
  input logic               rst_wdog,
  input logic               trap_req,
  input logic               swi_req,
  input logic               xirq_req,
  input logic [NUM_IRQ-1:0] irq_req,
  input logic [NUM_IRQ-1:0] irq_en,
  input logic               i_mask,
  input logic               x_mask,
  input logic [ADDR_W-1:0]  vec_base,
  input logic               vec_req,
  input logic [ADDR_W-1:0]  vec_addr,
  input logic               vec_valid
);

  logic no_rst;
  logic nothing;
  assign no_rst  = !rst_ext && !rst_clkmon && !rst_wdog;
  assign nothing = no_rst && !trap_req && !swi_req && !(xirq_req && !x_mask)
                   && (i_mask || ((irq_req & irq_en) == '0));

  a_r1_valid_after_req: assert property (@(posedge clk) disable iff (rst)
    vec_req |=> vec_valid);
  a_r1_no_valid_idle: assert property (@(posedge clk) disable iff (rst)
    !vec_req |=> !vec_valid);
  a_r2_addr_hold: assert property (@(posedge clk) disable iff (rst)
    !vec_req |=> $stable(vec_addr));
  a_r3_ext_reset_abs: assert property (@(posedge clk) disable iff (rst)
    (vec_req && rst_ext) |=> (vec_addr == ADDR_W'(32'hFFFE)));
  a_r3_clkmon_abs: assert property (@(posedge clk) disable iff (rst)
    (vec_req && !rst_ext && rst_clkmon) |=> (vec_addr == ADDR_W'(32'hFFFC)));
  a_r4_trap_vec: assert property (@(posedge clk) disable iff (rst)
    (vec_req && no_rst && trap_req) |=>
      (vec_addr == $past(vec_base) + ADDR_W'(32'hF8)));
  a_r5_xirq_vec: assert property (@(posedge clk) disable iff (rst)
    (vec_req && no_rst && !trap_req && !swi_req && xirq_req && !x_mask) |=>
      (vec_addr == $past(vec_base) + ADDR_W'(32'hF4)));
  a_r7_line0_top: assert property (@(posedge clk) disable iff (rst)
    (vec_req && no_rst && !trap_req && !swi_req && !(xirq_req && !x_mask)
     && !i_mask && irq_req[0] && irq_en[0]) |=>
      (vec_addr == $past(vec_base) + ADDR_W'(32'hF2)));
  a_r9_spurious: assert property (@(posedge clk) disable iff (rst)
    (vec_req && nothing) |=> (vec_addr == $past(vec_base) + ADDR_W'(32'h80)));

endmodule

bind exc_vec_resolver exc_vec_resolver_chk #(.ADDR_W(ADDR_W), .NUM_IRQ(NUM_IRQ)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .rst_ext    (rst_ext),
  .rst_clkmon (rst_clkmon),
  .rst_wdog   (rst_wdog),
  .trap_req   (trap_req),
  .swi_req    (swi_req),
  .xirq_req   (xirq_req),
  .irq_req    (irq_req),
  .irq_en     (irq_en),
  .i_mask     (i_mask),
  .x_mask     (x_mask),
  .vec_base   (vec_base),
  .vec_req    (vec_req),
  .vec_addr   (vec_addr),
  .vec_valid  (vec_valid)
);

// File: tb/exc_vec_resolver_tb.sv
module exc_vec_resolver_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int NI = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rst_ext = 0, rst_clkmon = 0, rst_wdog = 0;
  logic trap_req = 0, swi_req = 0, xirq_req = 0;
  logic [NI-1:0] irq_req = '0, irq_en = '0;
  logic i_mask = 1, x_mask = 1;
  logic [AW-1:0] vec_base = '0;
  logic vec_req = 0;
  logic [AW-1:0] vec_addr;
  logic vec_valid;

  int total = 0;
  int bad = 0;
  logic [AW-1:0] exp_addr = '0;
  logic exp_valid = 1'b0;
  string exp_rule = "R2";

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_vec_resolver #(.ADDR_W(AW), .NUM_IRQ(NI)) u_dut (
    .clk(clk), .rst(rst), .rst_ext(rst_ext), .rst_clkmon(rst_clkmon),
    .rst_wdog(rst_wdog), .trap_req(trap_req), .swi_req(swi_req),
    .xirq_req(xirq_req), .irq_req(irq_req), .irq_en(irq_en),
    .i_mask(i_mask), .x_mask(x_mask), .vec_base(vec_base),
    .vec_req(vec_req), .vec_addr(vec_addr), .vec_valid(vec_valid)
  );

  // Behavioural reference: priority list walked top-down.
  function automatic logic [AW-1:0] ref_vec(output string rule);
    int hits;
    int first;
    hits = 0;
    first = -1;
    if (rst_ext)    begin rule = "R3"; return 16'hFFFE; end
    if (rst_clkmon) begin rule = "R3"; return 16'hFFFC; end
    if (rst_wdog)   begin rule = "R3"; return 16'hFFFA; end
    if (trap_req)   begin rule = "R4"; return vec_base + 16'h00F8; end
    if (swi_req)    begin rule = "R4"; return vec_base + 16'h00F6; end
    if (xirq_req && !x_mask) begin rule = "R5"; return vec_base + 16'h00F4; end
    if (!i_mask) begin
      for (int i = 0; i < NI; i++) begin
        if (irq_req[i] && irq_en[i]) begin
          hits++;
          if (first < 0) first = i;
        end
      end
    end
    if (first >= 0) begin
      rule = (hits > 1) ? "R7" : "R6";
      return vec_base + 16'(242 - 2 * first);
    end
    rule = "R9";
    return vec_base + 16'h0080;
  endfunction

  task automatic chk(input string tag, input logic [AW-1:0] got, input logic [AW-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // One clock: model the register at the edge, compare at the falling edge.
  task automatic tick(input string tag = "");
    string r;
    @(posedge clk);
    if (rst) begin
      exp_addr = '0; exp_valid = 1'b0; r = "R2";
    end else begin
      exp_valid = vec_req;
      if (vec_req) exp_addr = ref_vec(r);
      else r = "R2";
    end
    @(negedge clk);
    chk((tag != "") ? tag : "R1", {15'b0, vec_valid}, {15'b0, exp_valid});
    chk((tag != "") ? tag : r, vec_addr, exp_addr);
  endtask

  task automatic clear_all();
    rst_ext = 0; rst_clkmon = 0; rst_wdog = 0;
    trap_req = 0; swi_req = 0; xirq_req = 0;
    irq_req = '0; irq_en = '0; i_mask = 0; x_mask = 0; vec_req = 0;
  endtask

  task automatic strobe(input string tag);
    vec_req = 1; tick(tag);
    vec_req = 0; tick(tag);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    @(negedge clk);
    tick("R2"); tick("R2");
    rst = 0;
    tick("R2");
    clear_all();
    vec_base = 16'h4000;

    // R3: reset causes override everything and ignore the base
    rst_ext = 1; rst_clkmon = 1; rst_wdog = 1; trap_req = 1; swi_req = 1;
    irq_req = '1; irq_en = '1;
    strobe("R3");
    rst_ext = 0; strobe("R3");
    rst_clkmon = 0; strobe("R3");
    clear_all();

    // R4: trap above software interrupt
    trap_req = 1; swi_req = 1; xirq_req = 1; irq_req = '1; irq_en = '1;
    strobe("R4");
    trap_req = 0; strobe("R4");
    clear_all();

    // R5: X request unmasked, then masked (ignored -> spurious)
    xirq_req = 1; irq_req = 8'h01; irq_en = 8'h01;
    strobe("R5");
    x_mask = 1; irq_req = '0; strobe("R5");
    clear_all();

    // R6: single line, then each blocking condition
    irq_req = 8'h08; irq_en = 8'h08; strobe("R6");
    irq_en = 8'h00; strobe("R6");
    irq_en = 8'h08; i_mask = 1; strobe("R6");
    i_mask = 0; swi_req = 1; strobe("R6");
    swi_req = 0; x_mask = 1; xirq_req = 1; strobe("R6");
    clear_all();

    // R7: lowest index wins
    irq_req = 8'b0010_0100; irq_en = 8'hFF; strobe("R7");
    irq_req = 8'h80; strobe("R7");
    clear_all();

    // R8: late arbitration
    irq_req = 8'h20; irq_en = 8'hFF;
    tick("R8"); tick("R8");
    irq_req = 8'h22; strobe("R8");
    irq_req = 8'h00; tick("R8");
    strobe("R8");
    clear_all();

    // R2: inputs change with no strobe, output holds
    irq_req = 8'h01; irq_en = 8'h01; trap_req = 1; vec_base = 16'h1234;
    tick("R2"); tick("R2"); tick("R2");
    clear_all();

    // R9 and R10: spurious with base, wrap-around
    vec_base = 16'h2200; strobe("R9");
    vec_base = 16'hFFC0; trap_req = 1; strobe("R10");
    trap_req = 0; irq_req = 8'h01; irq_en = 8'h01; strobe("R10");
    clear_all();

    // R1 back-to-back strobes
    vec_req = 1; tick("R1"); tick("R1"); vec_req = 0; tick("R1");

    // Random phase, rule tag taken from the reference
    for (int n = 0; n < 3000; n++) begin
      rst_ext    = ($urandom_range(0, 31) == 0);
      rst_clkmon = ($urandom_range(0, 31) == 0);
      rst_wdog   = ($urandom_range(0, 31) == 0);
      trap_req   = ($urandom_range(0, 15) == 0);
      swi_req    = ($urandom_range(0, 15) == 0);
      xirq_req   = ($urandom_range(0, 7) == 0);
      x_mask     = $urandom_range(0, 1);
      i_mask     = ($urandom_range(0, 3) == 0);
      irq_req    = NI'($urandom);
      irq_en     = NI'($urandom);
      vec_base   = AW'($urandom);
      vec_req    = ($urandom_range(0, 2) == 0);
      tick();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule